// File: doc/BRIEF.md
# Double-Buffered DAC Code Register Bank

This block holds the digital codes for four voltage-output converter channels. Each channel has two stages. The first is a staging register that the register bus writes. The second is an active register whose value drives the converter code output. A bus write only changes the staging register. The converter keeps its previous code until a load event copies the staged value across.

Three sources can produce a load event, and a two-bit mode field in the configuration register chooses which one is active:

- **Pin mode.** An external active-low strobe. It is synchronised and must stay low for a minimum number of clock cycles. It fires at most once per low pulse.
- **Auto mode.** Each channel loads on the cycle after its staging register is written.
- **Mask mode.** A channel mask is written to a self-clearing load register.

When the bus reads a channel address, it gets the active code, never the pending staged one. A power-down bit in the configuration register raises a high-impedance indication for all outputs. The stored codes are left unchanged while this bit is set.

Top module: `dac_code_bank`

## Requirements
- R1: A write to a channel address (0x10 + channel, channels 0..3) updates only that channel's staging register. The code output does not change as a direct result of the write.
- R2: A channel's code output changes only on the clock edge that follows a load event for that channel. At all other times it holds its value.
- R3: A bus read of a channel address returns that channel's active code. Before a load, this is the old code. After a load, it is the staged code.
- R4: In pin mode, a low pulse on `load_n` that lasts at least MIN_LOW_CYC clock cycles loads all four channels. The outputs update on the (MIN_LOW_CYC+2)th rising edge after the pin falls. Only one load occurs per low pulse, however long it lasts. The pin must go high and fall again before another load can happen.
- R5: A low pulse on `load_n` that is shorter than MIN_LOW_CYC cycles causes no load.
- R6: The configuration register is at address 0x1B, and bits 5:4 select the load mode. 00 and 11 select pin mode. 01 selects auto mode. 10 selects mask mode. In modes 01 and 10, the pin is ignored.
- R7: In auto mode, a write to a channel updates that channel's code on the next clock edge after the write edge. Other channels are not affected.
- R8: In mask mode, a write to the load register at 0x1C loads the channels whose bits are set in bits 3:0 (bit i selects channel i). The load takes effect on the edge after the write, and the register then clears to 0. In other modes, writes to 0x1C are ignored.
- R9: Configuration bit 0 is power-down. When it is set, `out_hiz` is 1. Power-down leaves the stored codes unchanged, so they are driven again when the bit is cleared.
- R10: After reset, all staging and active codes are 0, power-down is off, the mode is pin mode, and the configuration register reads back 0x00.
- R11: Codes are straight binary over the full 8-bit range. Both 0x00 and 0xFF load and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address for both write and read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational readback of the register at `addr` |
| load_n | input | 1 | Asynchronous active-low load strobe |
| dac_code | output | 32 | Active codes, channel i in bits [8i+7:8i] |
| out_hiz | output | 1 | High when outputs are powered down |

## Verification
The load path is exercised in each mode with several patterns:

- **Staged writes with no strobe.** These show that staging and the active code are separate, and that readback follows the active code.
- **Low pulses of one, two and three cycles.** These locate the edge of the minimum-width qualifier.
- **A long low hold with a write in the middle of it.** This tells a single load per pulse apart from a level-sensitive load.
- **Mask writes naming one channel at a time.** These show that the load is per channel.

The same pulses and mask writes are also repeated in the modes that should ignore them. This shows that the mode field gates each source independently. Extreme codes are then loaded under power-down toggling to show that the stored values are kept.

// File: rtl/dac_code_bank.sv
module dac_code_bank #(
  parameter int NCH         = 4,
  parameter int CODE_W      = 8,
  parameter int ADDR_W      = 8,
  parameter int MIN_LOW_CYC = 2,
  parameter int CH_BASE     = 'h10,
  parameter int CFG_ADDR    = 'h1B,
  parameter int LD_ADDR     = 'h1C
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [CODE_W-1:0]     wdata,
  output logic [CODE_W-1:0]     rdata,
  input  logic                  load_n,
  output logic [NCH*CODE_W-1:0] dac_code,
  output logic                  out_hiz
);
  localparam int CNT_W = $clog2(MIN_LOW_CYC + 1);
  localparam logic [1:0] M_AUTO = 2'b01;
  localparam logic [1:0] M_MASK = 2'b10;

  logic [CODE_W-1:0] stage_q [NCH];
  logic [CODE_W-1:0] act_q   [NCH];
  logic [1:0]        mode_q;
  logic              pd_q;
  logic [NCH-1:0]    ldreg_q, auto_q, wr_hit, load_mask;
  logic [1:0]        sync_q;
  logic [CNT_W-1:0]  low_cnt;
  logic              pin_fire, pin_mode, cfg_wr, ld_wr;

  assign cfg_wr   = wr_en && addr == ADDR_W'(CFG_ADDR);
  assign ld_wr    = wr_en && addr == ADDR_W'(LD_ADDR);
  assign pin_mode = mode_q != M_AUTO && mode_q != M_MASK;
  assign pin_fire = !sync_q[1] && low_cnt == CNT_W'(MIN_LOW_CYC - 1);
  assign load_mask = ({NCH{pin_fire && pin_mode}}) | auto_q | ldreg_q;
  assign out_hiz  = pd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= 2'b11;
      low_cnt <= '0;
    end else begin
      sync_q <= {sync_q[0], load_n};
      if (sync_q[1])
        low_cnt <= '0;
      else if (low_cnt != CNT_W'(MIN_LOW_CYC))
        low_cnt <= low_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= 2'b00;
      pd_q    <= 1'b0;
      ldreg_q <= '0;
      auto_q  <= '0;
    end else begin
      if (cfg_wr) begin
        mode_q <= wdata[5:4];
        pd_q   <= wdata[0];
      end
      ldreg_q <= (ld_wr && mode_q == M_MASK) ? wdata[NCH-1:0] : '0;
      auto_q  <= (mode_q == M_AUTO) ? wr_hit : '0;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign wr_hit[i] = wr_en && addr == ADDR_W'(CH_BASE + i);
    assign dac_code[i*CODE_W +: CODE_W] = act_q[i];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stage_q[i] <= '0;
        act_q[i]   <= '0;
      end else begin
        if (wr_hit[i])    stage_q[i] <= wdata;
        if (load_mask[i]) act_q[i]   <= stage_q[i];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(CFG_ADDR)) rdata = CODE_W'({mode_q, 3'b000, pd_q});
    if (addr == ADDR_W'(LD_ADDR))  rdata = CODE_W'(ldreg_q);
    for (int i = 0; i < NCH; i++)
      if (addr == ADDR_W'(CH_BASE + i)) rdata = act_q[i];
  end

  // R2: no load event, no output movement
  p_hold_without_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_mask == '0) |=> $stable(dac_code));
  // R4: one load per qualified low pulse
  p_pin_single_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pin_fire |=> !pin_fire);
  // R6: pin ignored in mask mode
  p_mask_mode_ignores_pin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_MASK && ldreg_q == '0) |=> $stable(dac_code));
  // R8: load register self-clears
  p_ldreg_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ldreg_q != '0 && !ld_wr) |=> ldreg_q == '0);
  // R9: power-down only by a configuration write
  p_hiz_from_cfg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_hiz) |-> $past(cfg_wr));

  if (MIN_LOW_CYC >= 2) begin : g_width_chk
    // R5: a fire needs the pin low for more than one synchronised cycle
    p_short_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pin_fire |-> $past(!sync_q[1]));
  end
endmodule

// File: tb/dac_code_bank_tb.sv
module dac_code_bank_tb;
  logic clk = 0, rst_n = 0, wr_en = 0, load_n = 1;
  logic [7:0] addr = 0, wdata = 0, rdata;
  logic [31:0] dac_code;
  logic out_hiz;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  dac_code_bank u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .load_n(load_n), .dac_code(dac_code),
    .out_hiz(out_hiz));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; #1 v = rdata;
  endtask

  task automatic pulse(int n);
    @(negedge clk); load_n = 0;
    repeat (n) @(negedge clk);
    load_n = 1;
    repeat (5) @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R10 codes", dac_code, 0);
    chk("R10 hiz", out_hiz, 0);
    rd(8'h1B, v); chk("R10 cfg", v, 8'h00);
    rd(8'h12, v); chk("R10 ch2 read", v, 0);
  endtask

  task automatic t_write_hold;
    logic [7:0] v;
    wr(8'h10, 8'h11); wr(8'h11, 8'h22); wr(8'h12, 8'h33); wr(8'h13, 8'h44);
    idle(3);
    chk("R1 R2 no change after writes", dac_code, 0);
    rd(8'h11, v); chk("R3 read before load", v, 0);
  endtask

  task automatic t_pin_load;
    logic [7:0] v;
    pulse(3);
    chk("R4 pin load", dac_code, 32'h44332211);
    rd(8'h11, v); chk("R3 read after load", v, 8'h22);
  endtask

  task automatic t_pin_timing;
    wr(8'h11, 8'h5A);
    @(negedge clk); load_n = 0;
    idle(3);
    chk("R4 not yet loaded after 3 edges", dac_code[15:8], 8'h22);
    idle(1);
    chk("R4 loaded on edge MIN_LOW_CYC+2", dac_code[15:8], 8'h5A);
    load_n = 1; idle(3);
  endtask

  task automatic t_short;
    wr(8'h10, 8'h55);
    pulse(1);
    chk("R5 short pulse ignored", dac_code[7:0], 8'h11);
    pulse(2);
    chk("R4 minimum width loads", dac_code[7:0], 8'h55);
  endtask

  task automatic t_rearm;
    wr(8'h12, 8'h77);
    @(negedge clk); load_n = 0;
    idle(6);
    chk("R4 long pulse loads", dac_code[23:16], 8'h77);
    wr(8'h12, 8'h99);
    idle(6);
    chk("R4 single load per pulse", dac_code[23:16], 8'h77);
    load_n = 1; idle(3);
    chk("R4 release does not load", dac_code[23:16], 8'h77);
    pulse(2);
    chk("R4 re-armed load", dac_code[23:16], 8'h99);
  endtask

  task automatic t_auto;
    wr(8'h1B, 8'h10);
    wr(8'h13, 8'hA5);
    chk("R7 not yet loaded", dac_code[31:24], 8'h44);
    @(negedge clk);
    chk("R7 auto load", dac_code[31:24], 8'hA5);
    chk("R7 others untouched", dac_code[23:0], 32'h995A55);
  endtask

  task automatic t_mask;
    logic [7:0] v;
    wr(8'h1B, 8'h20);
    wr(8'h10, 8'h01); wr(8'h11, 8'h02);
    pulse(3);
    chk("R6 pin ignored in mask mode", dac_code[15:0], 16'h5A55);
    wr(8'h1C, 8'h01);
    @(negedge clk);
    chk("R8 mask ch0", dac_code[15:0], 16'h5A01);
    rd(8'h1C, v); chk("R8 self clear", v, 0);
    wr(8'h1C, 8'h02); @(negedge clk);
    chk("R8 mask ch1", dac_code[15:8], 8'h02);
    wr(8'h1B, 8'h00);
    wr(8'h11, 8'h03);
    wr(8'h1C, 8'h02); idle(2);
    chk("R8 ignored in pin mode", dac_code[15:8], 8'h02);
    wr(8'h1B, 8'h30);
    pulse(2);
    chk("R6 mode 11 acts as pin", dac_code[15:8], 8'h03);
  endtask

  task automatic t_pd;
    logic [7:0] v;
    wr(8'h1B, 8'h31);
    chk("R9 hiz on", out_hiz, 1);
    chk("R9 codes held", dac_code, 32'hA5990301);
    rd(8'h1B, v); chk("R6 R9 cfg readback", v, 8'h31);
    wr(8'h1B, 8'h30);
    chk("R9 hiz off", out_hiz, 0);
    chk("R9 codes restored", dac_code, 32'hA5990301);
  endtask

  task automatic t_range;
    logic [7:0] v;
    wr(8'h10, 8'hFF); wr(8'h11, 8'h00);
    pulse(2);
    chk("R11 full scale and zero", dac_code[15:0], 16'h00FF);
    rd(8'h10, v); chk("R11 read 0xFF", v, 8'hFF);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset; t_write_hold; t_pin_load; t_pin_timing; t_short; t_rearm;
    t_auto; t_mask; t_pd; t_range;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule